// File: doc/BRIEF.md
# Prescaled Watchdog Timer

The block watches for a stalled processor. A prescaler divides the clock by a power of two, and each divided tick advances an 8-bit watchdog counter. When that counter wraps from all-ones back to zero, the block raises a one-cycle reset request. In the same cycle it raises a time-out pulse, which a status-flag block elsewhere records.

Software picks the division ratio by writing a byte to the select port. Only the three low bits of that byte are kept, and they give a ratio from 1 to 128. Software keeps the system alive by issuing the clear command before the counter wraps. The halt command also restarts the timer. Both commands zero the prescaler and the counter. While count enable is low, the timer holds its state.

Top module: `wdt_prescaled`

## Requirements
- R1: A write stores bits [2:0] of `sel_wdata_i` as the select value `s`. Bits [7:3] have no effect on the period.
- R2: After power-up reset, `s` is 7, so the first overflow comes 32768 enabled cycles after reset is released.
- R3: The division ratio is 2^s. With count enable held high, the first reset request comes 256·2^s cycles after the clock edge that applied a clear.
- R4: While `cnt_en_i` is low, neither the prescaler nor the counter advances, so the period grows by the number of disabled cycles.
- R5: A clear command zeroes the prescaler and the counter at the same edge, and the full period restarts from that edge.
- R6: A halt command restarts the prescaler and the counter in the same way as a clear.
- R7: An overflow gives a `rst_req_o` pulse exactly one cycle long. The counter restarts from zero, so without a clear the next pulse comes one full period later.
- R8: `timeout_o` pulses in the same cycles as `rst_req_o`.
- R9: A clear or halt in the cycle of the overflowing tick takes priority: no pulse appears, and the full period starts again.
- R10: While `rst_ni` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| sel_we_i | input | 1 | Write strobe for the select value |
| sel_wdata_i | input | 8 | Write data; only bits [2:0] are kept |
| clr_i | input | 1 | Clear-watchdog command |
| halt_i | input | 1 | Halt command; restarts the timer |
| cnt_en_i | input | 1 | Count enable |
| rst_req_o | output | 1 | One-cycle system reset request |
| timeout_o | output | 1 | One-cycle time-out event |

## Verification
Two functions can fall in the same cycle: the overflowing tick and a restart by clear or halt. The bench provokes this by computing the cycle in which the wrap would land and asserting clear, and in a second run halt, in exactly that cycle. It judges the result by checking that no pulse appears at the cycle the bench had predicted. The only pulse it accepts is the one a full period after the restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned PRE_W   = (1 << SEL_W) - 1;
  localparam logic [SEL_W-1:0] SEL_RST = '1;
endpackage

// File: rtl/wdt_sel_reg.sv
module wdt_sel_reg
  import wdt_pkg::*;
#(
  parameter int unsigned SW = SEL_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [SW-1:0] sel_o
);
  logic [SW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= SEL_RST;
    else if (we_i) sel_q <= wdata_i[SW-1:0];
  end

  assign sel_o = sel_q;

  assert_sel_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(sel_q));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned SW = SEL_W,
  parameter int unsigned PW = (1 << SW) - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          en_i,
  input  logic [SW-1:0] sel_i,
  output logic          tick_o
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;

  // mask holds the low sel_i bits set
  for (genvar i = 0; i < PW; i++) begin : g_mask
    assign mask[i] = (32'(sel_i) > i);
  end

  assign tick_o = en_i && !restart_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (en_i)      pre_q <= pre_q + PW'(1);
  end

  assert_pre_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pre_q == '0));
  assert_pre_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !restart_i) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_main_cnt.sv
module wdt_main_cnt
  import wdt_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic ovf_o,
  output logic req_o
);
  logic [CW-1:0] cnt_q;
  logic          req_q;

  assign ovf_o = tick_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= ovf_o && !restart_i;
      if (restart_i)   cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign req_o = req_q;

  assert_cnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(cnt_q));
  assert_req_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  assert_wrap_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> (cnt_q == '0));
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_we_i,
  input  logic [DATA_W-1:0] sel_wdata_i,
  input  logic              clr_i,
  input  logic              halt_i,
  input  logic              cnt_en_i,
  output logic              rst_req_o,
  output logic              timeout_o
);
  logic [SEL_W-1:0] sel;
  logic             restart;
  logic             tick;
  logic             ovf;
  logic             req;
  logic             to_q;

  assign restart = clr_i || halt_i;

  wdt_sel_reg #(.SW(SEL_W), .DW(DATA_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sel_we_i),
    .wdata_i(sel_wdata_i),
    .sel_o  (sel)
  );

  wdt_prescaler #(.SW(SEL_W), .PW(PRE_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .en_i     (cnt_en_i),
    .sel_i    (sel),
    .tick_o   (tick)
  );

  wdt_main_cnt #(.CW(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .tick_i   (tick),
    .ovf_o    (ovf),
    .req_o    (req)
  );

  // time-out event kept in its own flop for the status block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) to_q <= 1'b0;
    else         to_q <= ovf && !restart;
  end

  assign rst_req_o = req;
  assign timeout_o = to_q;

  assert_restart_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !rst_req_o);
  assert_ovf_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !restart) |=> rst_req_o);
  assert_to_with_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o == timeout_o);
  always_comb begin
    if (!rst_ni) assert_reset_low_R10: assert (!rst_req_o && !timeout_o);
  end
endmodule

// File: tb/wdt_prescaled_test.sv
module wdt_prescaled_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_we_i = 1'b0;
  logic [7:0] sel_wdata_i = '0;
  logic       clr_i = 1'b0;
  logic       halt_i = 1'b0;
  logic       cnt_en_i = 1'b1;
  logic       rst_req_o;
  logic       timeout_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_pulse = 0;
  bit prev_req = 1'b0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  wdt_prescaled uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: scoreboard of expected pulse cycles
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (prev_req) check(!rst_req_o, "R7", int'(rst_req_o), 0);
      if (rst_req_o) begin
        last_pulse = cyc;
        check(timeout_o, "R8", int'(timeout_o), 1);
        if (exp_q.size() == 0) check(1'b0, "unexpected pulse", cyc, -1);
        else begin
          check(exp_q[0] == cyc, tag_q[0], cyc, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (exp_q.size() != 0 && cyc > exp_q[0]) begin
        check(1'b0, tag_q[0], cyc, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (timeout_o && !rst_req_o) check(1'b0, "R8", 1, 0);
      prev_req = rst_req_o;
    end
  end

  task automatic expect_at(input int c, input string tag);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // one-cycle restart; optional select write; returns the drive cycle
  task automatic restart(input bit use_halt, input bit we, input logic [7:0] d, output int p);
    @(negedge clk_i);
    p = cyc;
    clr_i = !use_halt;
    halt_i = use_halt;
    sel_we_i = we;
    sel_wdata_i = d;
    @(negedge clk_i);
    clr_i = 1'b0;
    halt_i = 1'b0;
    sel_we_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int p;
    int e;
    // R10: outputs low while in reset
    repeat (3) @(negedge clk_i);
    check(!rst_req_o && !timeout_o, "R10", int'(rst_req_o | timeout_o), 0);
    rst_ni = 1'b1;
    // R2: default select 7, period 32768
    expect_at(cyc + 32768, "R2");
    drain();

    // R1: upper bits ignored, 0xF8 gives select 0
    restart(1'b0, 1'b1, 8'hF8, p);
    expect_at(p + 1 + 256, "R1");
    drain();
    // R7: free-running restart from zero, next pulse a full period later
    expect_at(last_pulse + 256, "R7");
    drain();

    // R3: select 1
    restart(1'b0, 1'b1, 8'h01, p);
    expect_at(p + 1 + 512, "R3");
    drain();
    // R1/R3: 0xFB gives select 3
    restart(1'b0, 1'b1, 8'hFB, p);
    expect_at(p + 1 + 2048, "R1");
    drain();

    // R4: enable low for 100 cycles
    restart(1'b0, 1'b1, 8'h00, p);
    cnt_en_i = 1'b0;
    repeat (100) @(negedge clk_i);
    cnt_en_i = 1'b1;
    expect_at(p + 1 + 256 + 100, "R4");
    drain();

    // R5: clear part-way through
    restart(1'b0, 1'b0, 8'h00, p);
    repeat (200) @(negedge clk_i);
    restart(1'b0, 1'b0, 8'h00, p);
    expect_at(p + 1 + 256, "R5");
    drain();

    // R6: halt part-way through
    restart(1'b0, 1'b0, 8'h00, p);
    repeat (150) @(negedge clk_i);
    restart(1'b1, 1'b0, 8'h00, p);
    expect_at(p + 1 + 256, "R6");
    drain();

    // R9: clear on the overflowing tick
    restart(1'b0, 1'b0, 8'h00, p);
    e = p + 1 + 256;
    while (cyc < e - 1) @(negedge clk_i);
    clr_i = 1'b1;
    expect_at(e + 256, "R9");
    @(negedge clk_i);
    clr_i = 1'b0;
    drain();

    // R9: halt on the overflowing tick
    restart(1'b0, 1'b0, 8'h00, p);
    e = p + 1 + 256;
    while (cyc < e - 1) @(negedge clk_i);
    halt_i = 1'b1;
    expect_at(e + 256, "R9");
    @(negedge clk_i);
    halt_i = 1'b0;
    drain();

    check(exp_q.size() == 0, "queue empty", exp_q.size(), 0);
    finish_run();
  end
endmodule